// File: doc/BRIEF.md
# Multi-Link Deterministic Alignment Sequencer

This block brings a group of serial converter receive links into a common multiframe phase. It stays idle until software enables it, then waits for the converters' configuration to be reported complete. Next it watches the comma (K-code) lock flag of every lane of every link. Once all of them are up, it raises a one-cycle request to the external clock generator for a SYSREF burst.

The SYSREF line that returns to the logic passes through a two-flop synchronizer and a rising-edge detector. The sequencer acts only on the first rising edge that arrives after its own request. On that edge it restarts the local multiframe clock (LMFC) counter of every link at the same instant, so all links leave the alignment step with identical phase. The counter period is the product of frames per multiframe and octets per frame.

Two failure paths are covered. If lane lock is not reached in time, the sequencer parks in a failure state and sets a sticky timeout flag. If lock is lost after alignment, it falls back to waiting for lock and sets a sticky resync flag. A status word exposes the state code and both flags.

Top module: `mlink_align_seq`

## Requirements
- R1: While reset is asserted the status word reads 0 (state code IDLE=0, both flags 0), `sysref_req` is 0 and every LMFC phase is 0.
- R2: With `seq_en` high, IDLE moves to WAIT_CFG (code 1) on the next edge. WAIT_CFG moves to WAIT_KCODE (code 2) only on an edge where `cfg_done` is high. Lane lock seen during WAIT_CFG causes no request.
- R3: WAIT_KCODE moves to REQ_SYSREF (code 3) only on an edge where all lock bits are 1. A single clear bit, at any lane position, holds the state at WAIT_KCODE.
- R4: `sysref_req` is 1 exactly while the state is REQ_SYSREF. That state lasts one cycle and is followed by WAIT_SYSREF (code 4).
- R5: In WAIT_SYSREF, a rise of `sysref_in` sampled at edge E moves the state to ALIGNED (code 5) at edge E+2. At that same edge every link's phase is set to 0, so all links show equal phase from then on.
- R6: SYSREF rises outside WAIT_SYSREF are ignored: the state does not change and the LMFC phases keep counting without a restart. This includes rises in WAIT_CFG and further rises in ALIGNED.
- R7: Each LMFC phase counts up by one per cycle from 0 to P-1 and then wraps to 0, where P = `frames_per_mf` × `octets_per_frame`. A product of 0 acts as P = 1, which holds the phase at 0.
- R8: The sequencer may stay in WAIT_KCODE for at most `tmo_limit`+1 consecutive cycles. If full lock is still missing on the edge after that, the state becomes FAIL (code 6) and status bit 3 (timeout) is set. FAIL is held until `seq_en` goes low. Full lock in the last allowed cycle still leads to REQ_SYSREF.
- R9: Loss of any lane lock while ALIGNED moves the state to WAIT_KCODE and sets status bit 4 (resync).
- R10: `seq_en` low moves any state to IDLE on the next edge. Both flags are sticky and are cleared only on the IDLE-to-WAIT_CFG edge.
- R11: Loss of any lane lock during WAIT_SYSREF moves the state back to WAIT_KCODE without setting the resync flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seq_en | input | 1 | Enables the sequence; low returns it to IDLE |
| cfg_done | input | 1 | Converter configuration has been issued |
| lane_kcode | input | NUM_LINKS*LANES_PER_LINK | Per-lane comma lock; bit l*LANES_PER_LINK+j is lane j of link l |
| tmo_limit | input | TMO_W | Lock wait limit in cycles, minus one |
| frames_per_mf | input | FPM_W | Frames per multiframe |
| octets_per_frame | input | OPF_W | Octets per frame |
| sysref_req | output | 1 | One-cycle request to the clock generator |
| sysref_in | input | 1 | Returned SYSREF, asynchronous |
| lmfc_phase | output | NUM_LINKS*(FPM_W+OPF_W) | LMFC phase per link; link l in slice l |
| seq_status | output | 5 | [2:0] state code, [3] timeout flag, [4] resync flag |

## Verification
Every state and flag change appears one edge after the input that causes it. `sysref_req` appears one edge after full lock is seen in WAIT_KCODE. The realignment appears at the third edge after `sysref_in` is driven high: two edges fill the synchronizer and the third acts on the detected edge. After the realigning edge, each LMFC phase equals n mod P. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next one, stepping whole cycles and counting them to match these latencies. A small three-link configuration allows a sweep of the missing-lane position and of the period over a grid of frame and octet counts.

// File: rtl/mlink_align_pkg.sv
package mlink_align_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_CFG  = 3'd1,
    ST_WAIT_LOCK = 3'd2,
    ST_REQ       = 3'd3,
    ST_WAIT_REF  = 3'd4,
    ST_ALIGNED   = 3'd5,
    ST_FAIL      = 3'd6
  } seq_state_e;
endpackage

// File: rtl/kcode_gather.sv
module kcode_gather #(
  parameter int NUM_LINKS      = 9,
  parameter int LANES_PER_LINK = 2,
  localparam int NLANES        = NUM_LINKS * LANES_PER_LINK
) (
  input  logic [NLANES-1:0] lane_kcode,
  output logic              all_lock
);
  logic [NUM_LINKS-1:0] link_ok;

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    assign link_ok[l] = &lane_kcode[l*LANES_PER_LINK +: LANES_PER_LINK];
  end

  assign all_lock = &link_ok;
endmodule

// File: rtl/sysref_edge.sv
module sysref_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sysref_in,
  output logic ref_rise
);
  logic [2:0] sync_q;
  logic [2:0] sync_nxt;

  assign sync_nxt = {sync_q[1:0], sysref_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign ref_rise = sync_q[1] & ~sync_q[2];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !ref_rise); // R5
endmodule

// File: rtl/lmfc_counter.sv
module lmfc_counter #(
  parameter int PH_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            align,
  input  logic [PH_W-1:0] last,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] cnt_nxt;

  always_comb begin
    if (align)             cnt_nxt = '0;
    else if (cnt_q >= last) cnt_nxt = '0;
    else                   cnt_nxt = cnt_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign phase = cnt_q;
endmodule

// File: rtl/align_fsm.sv
module align_fsm
  import mlink_align_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_en,
  input  logic             cfg_done,
  input  logic             all_lock,
  input  logic             ref_rise,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [2:0]       state_o,
  output logic             align_o,
  output logic             req_o,
  output logic             err_o,
  output logic             resync_o
);
  seq_state_e       st_q, st_nxt;
  logic [TMO_W-1:0] tmr_q, tmr_nxt;
  logic             err_q, err_nxt;
  logic             rs_q, rs_nxt;
  logic             tmr_en;

  always_comb begin
    st_nxt  = st_q;
    err_nxt = err_q;
    rs_nxt  = rs_q;
    align_o = 1'b0;
    if (!seq_en) begin
      st_nxt = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_nxt  = ST_WAIT_CFG;
          err_nxt = 1'b0;
          rs_nxt  = 1'b0;
        end
        ST_WAIT_CFG:  if (cfg_done) st_nxt = ST_WAIT_LOCK;
        ST_WAIT_LOCK: begin
          if (all_lock) begin
            st_nxt = ST_REQ;
          end else if (tmr_q == tmo_limit) begin
            st_nxt  = ST_FAIL;
            err_nxt = 1'b1;
          end
        end
        ST_REQ:       st_nxt = ST_WAIT_REF;
        ST_WAIT_REF: begin
          if (!all_lock) begin
            st_nxt = ST_WAIT_LOCK;
          end else if (ref_rise) begin
            st_nxt  = ST_ALIGNED;
            align_o = 1'b1;
          end
        end
        ST_ALIGNED: begin
          if (!all_lock) begin
            st_nxt = ST_WAIT_LOCK;
            rs_nxt = 1'b1;
          end
        end
        ST_FAIL:      st_nxt = ST_FAIL;
        default:      st_nxt = ST_IDLE;
      endcase
    end
  end

  assign tmr_en  = (st_q == ST_WAIT_LOCK) && (st_nxt == ST_WAIT_LOCK);
  assign tmr_nxt = tmr_en ? tmr_q + TMO_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      err_q <= 1'b0;
      rs_q  <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      tmr_q <= tmr_nxt;
      err_q <= err_nxt;
      rs_q  <= rs_nxt;
    end
  end

  assign state_o  = st_q;
  assign req_o    = (st_q == ST_REQ);
  assign err_o    = err_q;
  assign resync_o = rs_q;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o); // R4
  AST_REQ_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(all_lock)); // R3
  AST_FAIL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL) |-> err_q); // R8
  AST_ALIGN_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ALIGNED) && ($past(st_q) != ST_ALIGNED)) |-> $past(ref_rise)); // R5
endmodule

// File: rtl/mlink_align_seq.sv
module mlink_align_seq
  import mlink_align_pkg::*;
#(
  parameter int NUM_LINKS      = 9,
  parameter int LANES_PER_LINK = 2,
  parameter int TMO_W          = 16,
  parameter int FPM_W          = 5,
  parameter int OPF_W          = 5,
  localparam int NLANES        = NUM_LINKS * LANES_PER_LINK,
  localparam int PH_W          = FPM_W + OPF_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      seq_en,
  input  logic                      cfg_done,
  input  logic [NLANES-1:0]         lane_kcode,
  input  logic [TMO_W-1:0]          tmo_limit,
  input  logic [FPM_W-1:0]          frames_per_mf,
  input  logic [OPF_W-1:0]          octets_per_frame,
  output logic                      sysref_req,
  input  logic                      sysref_in,
  output logic [NUM_LINKS*PH_W-1:0] lmfc_phase,
  output logic [4:0]                seq_status
);
  logic            all_lock;
  logic            ref_rise;
  logic            align;
  logic [2:0]      state;
  logic            err_flag;
  logic            rs_flag;
  logic [PH_W-1:0] mf_len;
  logic [PH_W-1:0] mf_last;

  kcode_gather #(.NUM_LINKS(NUM_LINKS), .LANES_PER_LINK(LANES_PER_LINK)) i_gather (
    .lane_kcode (lane_kcode),
    .all_lock   (all_lock)
  );

  sysref_edge i_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sysref_in (sysref_in),
    .ref_rise  (ref_rise)
  );

  align_fsm #(.TMO_W(TMO_W)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_en    (seq_en),
    .cfg_done  (cfg_done),
    .all_lock  (all_lock),
    .ref_rise  (ref_rise),
    .tmo_limit (tmo_limit),
    .state_o   (state),
    .align_o   (align),
    .req_o     (sysref_req),
    .err_o     (err_flag),
    .resync_o  (rs_flag)
  );

  assign mf_len  = PH_W'(frames_per_mf) * PH_W'(octets_per_frame);
  assign mf_last = (mf_len == '0) ? '0 : mf_len - PH_W'(1);

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_lmfc
    lmfc_counter #(.PH_W(PH_W)) i_lmfc (
      .clk   (clk),
      .rst_n (rst_n),
      .align (align),
      .last  (mf_last),
      .phase (lmfc_phase[l*PH_W +: PH_W])
    );
  end

  for (genvar l = 1; l < NUM_LINKS; l++) begin : g_chk
    AST_LINKS_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      lmfc_phase[l*PH_W +: PH_W] == lmfc_phase[PH_W-1:0]); // R5
  end

  assign seq_status = {rs_flag, err_flag, state};
endmodule

// File: tb/test_mlink_align_seq.sv
`timescale 1ns/1ps
module test_mlink_align_seq;
  localparam int NL   = 3;
  localparam int LPL  = 2;
  localparam int NLN  = NL * LPL;
  localparam int PH_W = 10;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               seq_en, cfg_done, sysref_in;
  logic [NLN-1:0]     lane_kcode;
  logic [15:0]        tmo_limit;
  logic [4:0]         frames_per_mf, octets_per_frame;
  logic               sysref_req;
  logic [NL*PH_W-1:0] lmfc_phase;
  logic [4:0]         seq_status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mlink_align_seq #(.NUM_LINKS(NL), .LANES_PER_LINK(LPL)) i_mlink_align_seq (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .cfg_done(cfg_done),
    .lane_kcode(lane_kcode), .tmo_limit(tmo_limit),
    .frames_per_mf(frames_per_mf), .octets_per_frame(octets_per_frame),
    .sysref_req(sysref_req), .sysref_in(sysref_in),
    .lmfc_phase(lmfc_phase), .seq_status(seq_status)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ph(input int l);
    return int'(lmfc_phase[l*PH_W +: PH_W]);
  endfunction

  task automatic chk_phases(input string req, input int exp);
    for (int l = 0; l < NL; l++) chk(req, ph(l), exp);
  endtask

  // drives the SYSREF line high and steps to the realigning edge (third edge)
  task automatic send_sysref();
    sysref_in = 1'b1;
    tick();
    tick();
    chk("R5 not yet aligned", int'(seq_status[2:0]), 4);
    tick();
    sysref_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    int per;
    rst_n = 1'b0; seq_en = 1'b0; cfg_done = 1'b0; sysref_in = 1'b0;
    lane_kcode = '0; tmo_limit = 16'd1000;
    frames_per_mf = 5'd4; octets_per_frame = 5'd2;
    repeat (3) tick();
    // R1 reset state
    chk("R1 status", int'(seq_status), 0);
    chk("R1 req", int'(sysref_req), 0);
    chk_phases("R1 phase", 0);
    rst_n = 1'b1;
    tick();

    // R2 enable and configuration gating
    seq_en = 1'b1; lane_kcode = '1;
    tick();
    chk("R2 wait_cfg", int'(seq_status[2:0]), 1);
    repeat (3) tick();
    chk("R2 held without cfg", int'(seq_status[2:0]), 1);
    chk("R2 no request", int'(sysref_req), 0);
    cfg_done = 1'b1;
    tick();
    chk("R2 wait_kcode", int'(seq_status[2:0]), 2);
    tick();
    chk("R3 req state", int'(seq_status[2:0]), 3);
    chk("R4 req high", int'(sysref_req), 1);
    tick();
    chk("R4 wait_sysref", int'(seq_status[2:0]), 4);
    chk("R4 req low", int'(sysref_req), 0);
    send_sysref();
    chk("R5 aligned", int'(seq_status[2:0]), 5);
    chk_phases("R5 phase zero", 0);
    for (int n = 1; n <= 20; n++) begin
      tick();
      chk_phases("R7 count P=8", n % 8);
    end

    // R6 extra SYSREF while aligned is ignored
    p0 = ph(0);
    sysref_in = 1'b1; tick(); sysref_in = 1'b0;
    repeat (6) tick();
    chk_phases("R6 aligned ignore", (p0 + 7) % 8);
    chk("R6 state", int'(seq_status[2:0]), 5);

    // R9 lock loss after alignment
    lane_kcode[3] = 1'b0;
    tick();
    chk("R9 back to wait", int'(seq_status[2:0]), 2);
    chk("R9 resync flag", int'(seq_status[4]), 1);
    lane_kcode = '1;
    tick(); tick();
    send_sysref();
    chk("R9 realigned", int'(seq_status[2:0]), 5);
    chk("R10 resync sticky", int'(seq_status[4]), 1);

    // R10 disable and restart clears flags
    seq_en = 1'b0;
    tick();
    chk("R10 idle", int'(seq_status[2:0]), 0);
    chk("R10 flag held in idle", int'(seq_status[4]), 1);
    seq_en = 1'b1;
    tick();
    chk("R10 flags cleared", int'(seq_status), 1);

    // R3 sweep of the missing lane
    for (int i = 0; i < NLN; i++) begin
      lane_kcode = '1;
      lane_kcode[i] = 1'b0;
      tick();
      chk("R3 enter wait", int'(seq_status[2:0]), 2);
      repeat (3) tick();
      chk("R3 held one lane missing", int'(seq_status[2:0]), 2);
      chk("R3 no req", int'(sysref_req), 0);
      lane_kcode = '1;
      tick();
      chk("R3 all locked", int'(seq_status[2:0]), 3);
      seq_en = 1'b0; tick();
      seq_en = 1'b1; tick();
    end

    // R8 timeout
    tmo_limit = 16'd5; lane_kcode = '0;
    tick();
    chk("R8 wait", int'(seq_status[2:0]), 2);
    repeat (5) tick();
    chk("R8 last allowed cycle", int'(seq_status[2:0]), 2);
    tick();
    chk("R8 fail", int'(seq_status[2:0]), 6);
    chk("R8 timeout flag", int'(seq_status[3]), 1);
    lane_kcode = '1;
    repeat (3) tick();
    chk("R8 fail held", int'(seq_status[2:0]), 6);
    seq_en = 1'b0; tick();
    chk("R10 idle after fail", int'(seq_status[2:0]), 0);
    chk("R10 timeout sticky", int'(seq_status[3]), 1);
    seq_en = 1'b1; tick();
    chk("R10 cleared", int'(seq_status), 1);

    // R8 boundary: lock in the last allowed cycle
    lane_kcode = '0;
    tick();
    repeat (5) tick();
    lane_kcode = '1;
    tick();
    chk("R8 boundary req", int'(seq_status[2:0]), 3);
    chk("R8 boundary no flag", int'(seq_status[3]), 0);

    // R11 lock loss during WAIT_SYSREF
    tick();
    chk("R11 wait_sysref", int'(seq_status[2:0]), 4);
    lane_kcode[5] = 1'b0;
    tick();
    chk("R11 back to wait", int'(seq_status[2:0]), 2);
    chk("R11 no resync", int'(seq_status[4]), 0);

    // R6 SYSREF in WAIT_CFG is ignored
    tmo_limit = 16'd1000;
    seq_en = 1'b0; cfg_done = 1'b0; tick();
    seq_en = 1'b1; tick();
    p0 = ph(0);
    sysref_in = 1'b1; tick(); sysref_in = 1'b0;
    repeat (6) tick();
    chk_phases("R6 wait_cfg ignore", (p0 + 7) % 8);
    chk("R6 state held", int'(seq_status[2:0]), 1);

    // R7 period sweep
    for (int f = 0; f <= 4; f++) begin
      for (int k = 1; k <= 3; k++) begin
        frames_per_mf = 5'(f); octets_per_frame = 5'(k);
        per = (f * k == 0) ? 1 : f * k;
        seq_en = 1'b0; tick();
        seq_en = 1'b1; cfg_done = 1'b1; lane_kcode = '1;
        repeat (4) tick();
        chk("R4 sweep wait_sysref", int'(seq_status[2:0]), 4);
        send_sysref();
        chk_phases("R5 sweep zero", 0);
        for (int n = 1; n <= 2 * per + 2; n++) begin
          tick();
          chk_phases("R7 sweep", n % per);
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule